// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 raw interrupt requests, conditions each one by a per-source polarity and trigger mode, and records them in a pending-status register. Software reads and writes a small word-wide register file to enable sources, mark some as critical, clear serviced requests with write-one-to-clear, and raise requests of its own through a separate set register. Enabled pending requests drive one of two outputs to the processor: a critical request line and a normal request line.

For fast dispatch the block also presents a vector address: a programmable base plus a fixed 512-byte stride times the index of the winning source. One configuration bit picks which end of the source range wins. Sources are numbered from the most significant bit: source N owns register bit 31-N.

Reads are combinational from the address; writes take effect on the clock edge at which the write enable is high.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero except polarity, which reads 0xFFFFFFFF; both request outputs are low.
- R2: Byte offsets: 0x00 pending status (read; a written one clears that bit), 0x04 status set (write-only, reads 0), 0x08 enable, 0x0C critical select, 0x10 polarity, 0x14 trigger mode, 0x18 masked status (read-only), 0x1C vector (read-only), 0x20 vector configuration. Writes to 0x18 and 0x1C have no effect.
- R3: Source N is bit 31-N of `irqIn` and of every register, so source 0 is the MSB (mask 0x80000000 >> N).
- R4: A polarity bit of 1 makes its input active high; 0 makes it active low.
- R5: With trigger bit 0 (level), the status bit is set on every clock edge at which the conditioned input is active, so a clear has no lasting effect until the input goes inactive.
- R6: With trigger bit 1 (edge), the status bit is set by an inactive-to-active transition of the conditioned input and stays set, even while the input stays active, until a one is written to it at 0x00.
- R7: Writing ones to 0x04 makes the matching status bits pending.
- R8: Masked status equals status AND enable; `critIrq` is high when a masked bit is also set in the critical register, `normIrq` when a masked bit is clear there.
- R9: With vector configuration bit 0 set, source 0 has top priority and the vector is (config with bits 1:0 cleared) + N*512 for the lowest-numbered masked source N.
- R10: With vector configuration bit 0 clear, source 31 has top priority and the vector is (config with bits 1:0 cleared) + (31-N)*512 for the highest-numbered masked source N.
- R11: The vector reads zero when no masked bit is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register |
| irqIn | input | 32 | Raw interrupt inputs, source N on bit 31-N |
| critIrq | output | 1 | Critical interrupt request |
| normIrq | output | 1 | Non-critical interrupt request |

## Verification
A corrupted pending bit shows at the request outputs and in the masked status one clock after the input or write that caused it, and a lost edge shows as a missing status bit that never returns while the input stays high. A wrong priority scan or stride shows only in the vector read, so the vector is checked with two pending sources under both priority settings, where a reversed scan gives a different address. Write-one-to-clear on an active level source and on a held edge source separates the two trigger modes within two cycles.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SET  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_EN   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CRIT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_POL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_MSK  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_VEC  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 6'h20;

  typedef struct packed {
    logic clrStat;
    logic setStat;
    logic wrEnable;
    logic wrCrit;
    logic wrPol;
    logic wrTrig;
    logic wrCfg;
  } regStrb_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STAT, SEL_EN, SEL_CRIT, SEL_POL,
    SEL_TRIG, SEL_MSK, SEL_VEC, SEL_CFG
  } rdSel_t;
endpackage

// File: rtl/vic_ctl.sv
module vic_ctl
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  output regStrb_t          strb,
  output rdSel_t            rdSel
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (regAddr)
        OFF_STAT: strb.clrStat  = 1'b1;
        OFF_SET:  strb.setStat  = 1'b1;
        OFF_EN:   strb.wrEnable = 1'b1;
        OFF_CRIT: strb.wrCrit   = 1'b1;
        OFF_POL:  strb.wrPol    = 1'b1;
        OFF_TRIG: strb.wrTrig   = 1'b1;
        OFF_CFG:  strb.wrCfg    = 1'b1;
        default:  strb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_STAT: rdSel = SEL_STAT;
      OFF_EN:   rdSel = SEL_EN;
      OFF_CRIT: rdSel = SEL_CRIT;
      OFF_POL:  rdSel = SEL_POL;
      OFF_TRIG: rdSel = SEL_TRIG;
      OFF_MSK:  rdSel = SEL_MSK;
      OFF_VEC:  rdSel = SEL_VEC;
      OFF_CFG:  rdSel = SEL_CFG;
      default:  rdSel = SEL_NONE;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R2
  AST_NO_WR_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb == '0)); // R2
endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STRIDE_LG = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] irqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              critIrq,
  output logic              normIrq
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] statReg, enReg, critReg, polReg, trigReg, cfgReg;
  logic [DATA_W-1:0] actPrev, actIn, edgeHit, hwSet, statNxt, masked;
  logic [IDX_W-1:0]  hiPos, loPos, vecOff;
  logic [DATA_W-1:0] vecBase, vecAddr;
  logic              anyPend;

  assign actIn   = ~(irqIn ^ polReg);
  assign edgeHit = actIn & ~actPrev;
  assign hwSet   = (trigReg & edgeHit) | (~trigReg & actIn);

  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    assign statNxt[b] = (statReg[b] & ~(strb.clrStat & wrData[b]))
                      | (strb.setStat & wrData[b])
                      | hwSet[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
      enReg   <= '0;
      critReg <= '0;
      polReg  <= '1;
      trigReg <= '0;
      cfgReg  <= '0;
      actPrev <= '0;
    end else begin
      statReg <= statNxt;
      actPrev <= actIn;
      if (strb.wrEnable) enReg   <= wrData;
      if (strb.wrCrit)   critReg <= wrData;
      if (strb.wrPol)    polReg  <= wrData;
      if (strb.wrTrig)   trigReg <= wrData;
      if (strb.wrCfg)    cfgReg  <= wrData;
    end
  end

  assign masked  = statReg & enReg;
  assign anyPend = |masked;
  assign critIrq = |(masked & critReg);
  assign normIrq = |(masked & ~critReg);

  always_comb begin
    hiPos = '0;
    for (int i = 0; i < DATA_W; i++)
      if (masked[i]) hiPos = IDX_W'(i);
  end

  always_comb begin
    loPos = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (masked[i]) loPos = IDX_W'(i);
  end

  assign vecOff  = cfgReg[0] ? (TOP_IDX - hiPos) : loPos;
  assign vecBase = {cfgReg[DATA_W-1:2], 2'b00};
  assign vecAddr = anyPend ? (vecBase + (DATA_W'(vecOff) << STRIDE_LG)) : '0;

  always_comb begin
    unique case (rdSel)
      SEL_STAT: rdData = statReg;
      SEL_EN:   rdData = enReg;
      SEL_CRIT: rdData = critReg;
      SEL_POL:  rdData = polReg;
      SEL_TRIG: rdData = trigReg;
      SEL_MSK:  rdData = masked;
      SEL_VEC:  rdData = vecAddr;
      SEL_CFG:  rdData = cfgReg;
      default:  rdData = '0;
    endcase
  end

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (masked == '0) |-> (vecAddr == '0)); // R11
  AST_VEC_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> (vecAddr[STRIDE_LG-1:0] == vecBase[STRIDE_LG-1:0])); // R9
  AST_OUT_NEEDS_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !anyPend |-> (!critIrq && !normIrq)); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStat |=> ((($past(statReg)) & ~statReg) == '0)); // R6
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|(actIn & ~trigReg)) |=> (($past(actIn & ~trigReg) & ~statReg) == '0)); // R5
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STRIDE_LG = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] irqIn,
  output logic              critIrq,
  output logic              normIrq
);
  regStrb_t strb;
  rdSel_t   rdSel;

  vic_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .strb(strb), .rdSel(rdSel)
  );

  vic_dp #(.DATA_W(DATA_W), .STRIDE_LG(STRIDE_LG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdSel(rdSel),
    .irqIn(irqIn), .rdData(rdData), .critIrq(critIrq), .normIrq(normIrq)
  );
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] irqIn = '0;
  logic        critIrq, normIrq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .critIrq(critIrq), .normIrq(normIrq)
  );

  function automatic logic [31:0] src(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); chk("R1 status", v, 32'h0);
    rd(6'h08, v); chk("R1 enable", v, 32'h0);
    rd(6'h10, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    rd(6'h20, v); chk("R1 config", v, 32'h0);
    rd(6'h1C, v); chk("R1 vector", v, 32'h0);
    chk("R1 outputs", {30'd0, critIrq, normIrq}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(6'h08, src(5));
    irqIn = src(5); settle();
    rd(6'h00, v); chk("R5 level pending", v, src(5));
    chk("R3 R8 normIrq level", {31'd0, normIrq}, 32'h1);
    wr(6'h00, src(5)); settle();
    rd(6'h00, v); chk("R5 clear while active", v, src(5));
    irqIn = '0; settle();
    wr(6'h00, src(5)); settle();
    rd(6'h00, v); chk("R5 clear when inactive", v, 32'h0);
    chk("R5 normIrq drop", {31'd0, normIrq}, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(6'h14, src(3));
    @(negedge clk) irqIn = src(3);
    @(negedge clk) irqIn = '0;
    settle();
    rd(6'h00, v); chk("R6 edge latched", v, src(3));
    irqIn = src(3); settle();
    wr(6'h00, src(3)); settle();
    rd(6'h00, v); chk("R6 held input no reset", v, 32'h0);
    irqIn = '0; settle();
    irqIn = src(3); settle();
    rd(6'h00, v); chk("R6 second edge", v, src(3));
    irqIn = '0;
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h14, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    wr(6'h10, ~src(7)); settle();
    rd(6'h00, v); chk("R4 active low pending", v, src(7));
    irqIn = src(7); settle();
    wr(6'h00, src(7)); settle();
    rd(6'h00, v); chk("R4 active low idle high", v, 32'h0);
    irqIn = '0;
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h00, 32'hFFFF_FFFF); settle();
    rd(6'h00, v); chk("R4 active high idle low", v, 32'h0);
  endtask

  task automatic t_set_crit();
    logic [31:0] v;
    wr(6'h04, src(10));
    wr(6'h08, src(10));
    wr(6'h0C, src(10)); settle();
    rd(6'h00, v); chk("R7 software set", v, src(10));
    rd(6'h04, v); chk("R2 set reads zero", v, 32'h0);
    chk("R8 critIrq", {30'd0, critIrq, normIrq}, 32'h2);
    wr(6'h08, 32'h0); settle();
    rd(6'h18, v); chk("R8 masked disabled", v, 32'h0);
    chk("R8 outputs disabled", {30'd0, critIrq, normIrq}, 32'h0);
    rd(6'h00, v); chk("R8 status kept", v, src(10));
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h0C, 32'h0);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    wr(6'h04, src(4) | src(20));
    wr(6'h08, src(4) | src(20) | src(9));
    wr(6'h20, 32'h0001_0003); settle();
    rd(6'h18, v); chk("R8 masked status", v, src(4) | src(20));
    rd(6'h1C, v); chk("R9 source0 first", v, 32'h0001_0000 + 4 * 512);
    wr(6'h20, 32'h0001_0002); settle();
    rd(6'h1C, v); chk("R10 source31 first", v, 32'h0001_0000 + (31 - 20) * 512);
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF); settle();
    rd(6'h18, v); chk("R2 masked read-only", v, src(4) | src(20));
    rd(6'h1C, v); chk("R2 vector read-only", v, 32'h0001_1600);
    wr(6'h00, 32'hFFFF_FFFF); settle();
    rd(6'h1C, v); chk("R11 vector idle", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_polarity();
    t_set_crit();
    t_vector();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule